// File: doc/BRIEF.md
# Distance Relay Fault Locator

This block turns one voltage magnitude and one current magnitude, both sampled at the relaying end of a protected line, into an estimate of how far along the line a fault lies. It first forms the apparent impedance as the ratio of voltage to current. It then scans a table of trained impedances, one entry per fixed distance step, for the segment that brackets that value. Finally it interpolates linearly between the two ends of that segment. The result is a distance in 1/1024 units of line length, a trip flag for faults inside the protected reach, and a one-cycle done strobe.

The trained table is written through a plain write port before measurements are applied. Entries must rise strictly with distance. The protected reach ends at the last table entry. A single restoring divider is shared by the ratio step and the interpolation step, one quotient bit per cycle. A sample is accepted only while the block is idle.

Top module: `dist_locator`

## Requirements
- R1: The apparent impedance is Z = floor(volt_i * 2^ZF / cur_i), and every distance decision uses this truncated Z.
- R2: A write with tbl_we high stores tbl_data into table entry tbl_addr (0 to NPTS-1). The search uses the first index i for which entry[i+1] >= Z, together with entry i.
- R3: Inside the reach the distance is floor((i*1024 + t) * STEP_PCT / 100), where t = floor((Z - entry[i]) * 1024 / (entry[i+1] - entry[i])). trip_o is 1 and dist_o never exceeds the reach value.
- R4: A Z below entry 0 gives dist_o = 0 with trip_o = 1.
- R5: A Z above entry NPTS-1 gives trip_o = 0 with dist_o = the reach value floor((NPTS-1)*1024*STEP_PCT/100), which is 819 by default. A Z equal to entry NPTS-1 still gives trip_o = 1.
- R6: A sample with cur_i = 0 starts no division. On the next cycle done_o and invalid_o are 1, trip_o is 0 and dist_o is 0, and busy_o stays low.
- R7: An accepted sample with nonzero current raises busy_o on the next cycle. busy_o falls in the same cycle that done_o pulses for one cycle, and each accepted sample gives exactly one done_o.
- R8: in_valid while busy_o is high is ignored. It produces no extra done_o and leaves the result of the running sample unchanged.
- R9: dist_o, trip_o and invalid_o change only in a cycle with done_o high and hold otherwise. invalid_o is 0 for every sample with nonzero current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| volt_i | input | VW | Voltage magnitude |
| cur_i | input | IW | Current magnitude |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | $clog2(NPTS) | Table write index |
| tbl_data | input | ZW | Trained impedance to store |
| dist_o | output | FRACB+1 | Estimated distance, 1/1024 of line length |
| trip_o | output | 1 | Fault inside protected reach |
| invalid_o | output | 1 | Sample had zero current |
| done_o | output | 1 | Result-ready pulse |
| busy_o | output | 1 | Computation in progress |

## Verification
The bench uses the default parameters: 12-bit voltage and current, 4 fractional impedance bits, a 16-bit table of 17 breakpoints at 5% steps, and 10 fraction bits of distance. With these values the reach value is 819. One current of 1 drives the impedance to its 16-bit ceiling, and a quadratic table gives segments of unequal width, so the bench can probe exact hits on the first and last breakpoints, the segment end where t reaches 1024, and both clamp regions. Rewriting a single entry after the first runs shows that the search follows the stored table.

// File: rtl/dl_pkg.sv
package dl_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DIVZ,
    S_FETCH,
    S_CMP,
    S_DIVT
  } dl_state_t;
endpackage

// File: rtl/dl_div.sv
module dl_div #(
  parameter int DW = 26
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [DW-1:0] quo
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] rem_q, den_q;
  logic [CW-1:0] cnt;
  logic          run;
  logic [DW:0]   shifted;
  logic          fits;
  logic [DW:0]   rem_n;

  always_comb begin
    shifted = {rem_q, quo[DW-1]};
    fits    = shifted >= {1'b0, den_q};
    rem_n   = fits ? shifted - {1'b0, den_q} : shifted;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      den_q <= '0;
      quo   <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        den_q <= den;
        quo   <= num;
        cnt   <= CW'(DW);
        run   <= 1'b1;
      end else if (run) begin
        rem_q <= rem_n[DW-1:0];
        quo   <= {quo[DW-2:0], fits};
        cnt   <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dl_table.sv
module dl_table #(
  parameter int N = 17,
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] waddr,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(N)-1:0] raddr,
  output logic [W-1:0]         rdata
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dist_locator.sv
module dist_locator #(
  parameter int VW       = 12,
  parameter int IW       = 12,
  parameter int ZF       = 4,
  parameter int ZW       = 16,
  parameter int NPTS     = 17,
  parameter int STEP_PCT = 5,
  parameter int FRACB    = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [VW-1:0]           volt_i,
  input  logic [IW-1:0]           cur_i,
  input  logic                    tbl_we,
  input  logic [$clog2(NPTS)-1:0] tbl_addr,
  input  logic [ZW-1:0]           tbl_data,
  output logic [FRACB:0]          dist_o,
  output logic                    trip_o,
  output logic                    invalid_o,
  output logic                    done_o,
  output logic                    busy_o
);
  import dl_pkg::*;

  localparam int IXW   = $clog2(NPTS);
  localparam int DW    = ZW + FRACB;
  localparam int DISTW = FRACB + 1;
  localparam int REACH = ((NPTS - 1) * (1 << FRACB) * STEP_PCT) / 100;
  localparam logic [IXW-1:0] LAST = IXW'(NPTS - 1);

  dl_state_t     st;
  logic [ZW-1:0] zmeas, zlo, rd;
  logic [IXW-1:0] idx;
  logic          accept, go_div, hit, div_start, div_done;
  logic [DW-1:0] div_num, div_den, div_q;
  logic [31:0]   seg_sum, dist_calc;

  always_comb begin
    accept    = in_valid && (st == S_IDLE);
    go_div    = accept && (cur_i != '0);
    hit       = (st == S_CMP) && (idx != '0) && (rd >= zmeas);
    div_start = go_div || hit;
    div_num   = (st == S_IDLE) ? DW'({volt_i, {ZF{1'b0}}}) : {zmeas - zlo, {FRACB{1'b0}}};
    div_den   = (st == S_IDLE) ? DW'(cur_i) : DW'(rd - zlo);
    seg_sum   = (32'(idx) - 32'd1) * (32'd1 << FRACB) + 32'(div_q);
    dist_calc = seg_sum * 32'(STEP_PCT) / 32'd100;
  end

  dl_div #(.DW(DW)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .done  (div_done),
    .quo   (div_q)
  );

  dl_table #(.N(NPTS), .W(ZW)) u_tbl (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_data),
    .raddr (idx),
    .rdata (rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      zmeas     <= '0;
      zlo       <= '0;
      idx       <= '0;
      dist_o    <= '0;
      trip_o    <= 1'b0;
      invalid_o <= 1'b0;
      done_o    <= 1'b0;
      busy_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (cur_i == '0) begin
            done_o    <= 1'b1;
            invalid_o <= 1'b1;
            trip_o    <= 1'b0;
            dist_o    <= '0;
          end else begin
            busy_o <= 1'b1;
            st     <= S_DIVZ;
          end
        end
        S_DIVZ: if (div_done) begin
          zmeas <= div_q[ZW-1:0];
          idx   <= '0;
          st    <= S_FETCH;
        end
        S_FETCH: st <= S_CMP;
        S_CMP: begin
          if (idx == '0) begin
            if (zmeas < rd) begin
              st        <= S_IDLE;
              busy_o    <= 1'b0;
              done_o    <= 1'b1;
              invalid_o <= 1'b0;
              trip_o    <= 1'b1;
              dist_o    <= '0;
            end else begin
              zlo <= rd;
              idx <= IXW'(1);
              st  <= S_FETCH;
            end
          end else if (rd >= zmeas) begin
            st <= S_DIVT;
          end else if (idx == LAST) begin
            st        <= S_IDLE;
            busy_o    <= 1'b0;
            done_o    <= 1'b1;
            invalid_o <= 1'b0;
            trip_o    <= 1'b0;
            dist_o    <= DISTW'(REACH);
          end else begin
            zlo <= rd;
            idx <= idx + 1'b1;
            st  <= S_FETCH;
          end
        end
        S_DIVT: if (div_done) begin
          st        <= S_IDLE;
          busy_o    <= 1'b0;
          done_o    <= 1'b1;
          invalid_o <= 1'b0;
          trip_o    <= 1'b1;
          dist_o    <= dist_calc[DISTW-1:0];
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dl_checker.sv
module dl_checker #(
  parameter int IW    = 12,
  parameter int DISTW = 11,
  parameter int REACH = 819
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IW-1:0]    cur_i,
  input logic [DISTW-1:0] dist_o,
  input logic             trip_o,
  input logic             invalid_o,
  input logic             done_o,
  input logic             busy_o
);
  p_zero_cur_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && !busy_o && cur_i == '0 |=> done_o && invalid_o && !trip_o && !busy_o);

  p_accept_busy_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && !busy_o && cur_i != '0 |=> busy_o && !done_o);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  p_fall_done_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    busy_o && in_valid && cur_i == '0 |=> !invalid_o);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(dist_o) && $stable(trip_o) && $stable(invalid_o));

  p_reach_r5: assert property (@(posedge clk) disable iff (rst)
    done_o && !trip_o && !invalid_o |-> dist_o == DISTW'(REACH));

  p_bound_r3: assert property (@(posedge clk) disable iff (rst)
    done_o && trip_o |-> dist_o <= DISTW'(REACH));
endmodule

bind dist_locator dl_checker #(.IW(IW), .DISTW(DISTW), .REACH(REACH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .cur_i     (cur_i),
  .dist_o    (dist_o),
  .trip_o    (trip_o),
  .invalid_o (invalid_o),
  .done_o    (done_o),
  .busy_o    (busy_o)
);

// File: tb/dist_locator_tb.sv
`timescale 1ns/1ps
module dist_locator_tb;
  localparam int NPTS = 17;
  localparam int REACH = 819;

  typedef struct {
    int    d;
    bit    t;
    bit    inv;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [11:0] volt_i, cur_i;
  logic        tbl_we;
  logic [4:0]  tbl_addr;
  logic [15:0] tbl_data;
  logic [10:0] dist_o;
  logic        trip_o, invalid_o, done_o, busy_o;

  int   nchk = 0, nfail = 0;
  int   tbl [NPTS];
  exp_t sb [$];
  int   last_d = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  dist_locator u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .volt_i(volt_i), .cur_i(cur_i),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .dist_o(dist_o), .trip_o(trip_o), .invalid_o(invalid_o),
    .done_o(done_o), .busy_o(busy_o)
  );

  task automatic check(bit ok, string req, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic exp_t model(int v, int c, string tag);
    exp_t e;
    int z, i, t;
    e.tag = tag; e.inv = 0; e.t = 0; e.d = 0;
    if (c == 0) begin
      e.inv = 1;
      return e;
    end
    z = (v * 16) / c;
    if (z < tbl[0]) begin
      e.t = 1;
    end else if (z > tbl[NPTS-1]) begin
      e.d = REACH;
    end else begin
      i = 0;
      while (tbl[i+1] < z) i++;
      t = ((z - tbl[i]) * 1024) / (tbl[i+1] - tbl[i]);
      e.d = ((i * 1024) + t) * 5 / 100;
      e.t = 1;
    end
    return e;
  endfunction

  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(dist_o == 11'(e.d), {e.tag, " dist"}, int'(dist_o), e.d);
        check(trip_o == e.t, {e.tag, " trip"}, int'(trip_o), int'(e.t));
        check(invalid_o == e.inv, {e.tag, " R9 invalid"}, int'(invalid_o), int'(e.inv));
        last_d = e.d;
      end
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 5'(a); tbl_data = 16'(d);
    tbl[a] = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic send(int v, int c, string tag);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    in_valid = 1'b1; volt_i = 12'(v); cur_i = 12'(c);
    sb.push_back(model(v, c, tag));
    @(negedge clk);
    in_valid = 1'b0;
    if (c != 0) check(busy_o == 1'b1, "R7 busy after accept", int'(busy_o), 1);
    else        check(busy_o == 1'b0, "R6 busy stays low", int'(busy_o), 0);
  endtask

  task automatic drain();
    while (sb.size() != 0 || busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; volt_i = '0; cur_i = '0;
    tbl_we = 1'b0; tbl_addr = '0; tbl_data = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done_o == 0 && busy_o == 0, "R7 reset idle", int'(done_o) + int'(busy_o), 0);
    check(dist_o == 0 && trip_o == 0 && invalid_o == 0, "R9 reset outputs",
          int'(dist_o), 0);

    for (int k = 0; k < NPTS; k++) wr(k, 200 + 50*k + 3*k*k);

    send(10, 16, "R4 below first");
    send(3, 7, "R4 small ratio");
    send(0, 5, "R4 zero voltage");
    send(200, 16, "R2 equal first");
    send(700, 9, "R1 truncated ratio");
    send(1000, 13, "R3 mid segment");
    send(253, 16, "R3 segment end");
    send(1768, 16, "R5 equal last");
    send(4000, 16, "R5 beyond reach");
    send(4095, 1, "R5 ratio ceiling");
    send(500, 0, "R6 zero current");
    send(600, 16, "R9 after invalid");
    drain();

    send(900, 16, "R8 first sample");
    in_valid = 1'b1; volt_i = 12'd10; cur_i = 12'd16;
    @(negedge clk);
    in_valid = 1'b1; volt_i = 12'd10; cur_i = 12'd0;
    @(negedge clk);
    in_valid = 1'b0;
    drain();
    repeat (5) @(negedge clk);
    check(dist_o == 11'(last_d), "R9 output held", int'(dist_o), last_d);
    check(done_o == 1'b0, "R8 no extra done", int'(done_o), 0);

    wr(0, 5);
    send(10, 16, "R2 rewritten entry");
    send(1500, 16, "R3 upper segment");
    drain();
    summary();
  end
endmodule